// File: doc/BRIEF.md
# Sequential Multiply/Divide Unit with HI/LO Result Registers

This block performs signed and unsigned multiplication and division of two W-bit operands. It computes one bit per clock and keeps the results in two result registers: HI and LO. A single-cycle start pulse carries a two-bit operation code and the two operands. The unit then works for W cycles. A multiply leaves the upper half of the 2W-bit product in HI and the lower half in LO. A divide leaves the remainder in HI and the quotient in LO.

A consumer asserts a read request when it wants HI or LO. The unit raises a stall output for as long as an operation is still running. Either register can also be written directly. Division by zero and the single signed overflow case never trap. Instead they leave fixed, well-defined values in HI and LO.

Top module: `hilo_muldiv`

## Requirements
- R1: With op = 2'b01 (unsigned multiply), HI:LO becomes the 2W-bit unsigned product of a and b.
- R2: With op = 2'b00 (signed multiply), HI:LO becomes the 2W-bit two's-complement product of a and b.
- R3: With op = 2'b11 (unsigned divide) and b nonzero, LO becomes the quotient a/b and HI becomes the remainder.
- R4: With op = 2'b10 (signed divide) and b nonzero, the quotient in LO is truncated toward zero and the remainder in HI has the sign of the dividend.
- R5: Divide by zero gives HI = a in every case. LO takes one of three values:
  - all ones for an unsigned divide;
  - -1 for a signed divide with a non-negative a;
  - +1 for a signed divide with a negative a.
- R6: A signed divide of the most negative value by -1 gives HI = 0 and LO = the most negative value, with no error indication.
- R7: A start is taken in one cycle. busy is high from the following cycle for exactly W cycles, and the results appear in HI/LO in the same cycle that busy falls.
- R8: stall equals rd_req while busy is high, and stays low whenever busy is low.
- R9: When start is low, wr_hi (or wr_lo) loads wr_data into HI (or LO) on the next cycle. Such a write during a running operation ends the operation at once, and the other register keeps its previous value.
- R10: A start while busy abandons the running operation. Only the new operation's results appear, W cycles after the new start.
- R11: A direct write in the same cycle as a start is ignored, and the operation's results land as usual.
- R12: While idle with no start and no write, HI and LO hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch an operation |
| op | input | 2 | Operation code. Bit 1: 1 = divide. Bit 0: 1 = unsigned |
| a | input | W | Multiplicand or dividend |
| b | input | W | Multiplier or divisor |
| wr_hi | input | 1 | Direct write of HI |
| wr_lo | input | 1 | Direct write of LO |
| wr_data | input | W | Data for direct writes |
| rd_req | input | 1 | Consumer wants to read HI or LO |
| hi | output | W | HI register |
| lo | output | W | LO register |
| busy | output | 1 | Operation in progress |
| stall | output | 1 | Read must wait |

## Verification
The hardest situations to reach are the ones where an operation is interrupted midway. One is a restart while busy. The other is a direct write that cancels the work while one result register must keep an older value. The bench reaches them by issuing a second start, or a write, a fixed number of cycles into a running divide. It seeds HI and LO with known patterns beforehand. The divide-by-zero and most-negative-over-minus-one patterns fall out of an exhaustive sweep of all operand pairs with a 4-bit width.

// File: rtl/hilo_muldiv.sv
module hilo_muldiv #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [1:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         wr_hi,
  input  logic         wr_lo,
  input  logic [W-1:0] wr_data,
  input  logic         rd_req,
  output logic [W-1:0] hi,
  output logic [W-1:0] lo,
  output logic         busy,
  output logic         stall
);
  localparam int CW = (W > 2) ? $clog2(W) : 1;

  logic [CW-1:0] cnt;
  logic          is_div, neg_q, neg_r;
  logic [W-1:0]  wa, wq, wd;

  wire sa = ~op[0] & a[W-1];
  wire sb = ~op[0] & b[W-1];
  wire [W-1:0] mag_a = sa ? -a : a;
  wire [W-1:0] mag_b = sb ? -b : b;

  wire [W:0]   msum = {1'b0, wa} + (wq[0] ? {1'b0, wd} : {(W+1){1'b0}});
  wire [W:0]   trial = {wa, wq[W-1]};
  wire [W+1:0] dsub = {1'b0, trial} - {2'b00, wd};
  wire         fits = ~dsub[W+1];

  wire [W-1:0] wa_n = is_div ? (fits ? dsub[W-1:0] : trial[W-1:0]) : msum[W:1];
  wire [W-1:0] wq_n = is_div ? {wq[W-2:0], fits} : {msum[0], wq[W-1:1]};

  wire [2*W-1:0] prod   = {wa_n, wq_n};
  wire [2*W-1:0] prod_f = neg_q ? -prod : prod;
  wire [W-1:0]   quo_f  = neg_q ? -wq_n : wq_n;
  wire [W-1:0]   rem_f  = neg_r ? -wa_n : wa_n;

  assign stall = rd_req & busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; cnt <= '0; is_div <= 1'b0; neg_q <= 1'b0; neg_r <= 1'b0;
      wa <= '0; wq <= '0; wd <= '0; hi <= '0; lo <= '0;
    end else if (start) begin
      busy   <= 1'b1;
      cnt    <= CW'(W - 1);
      is_div <= op[1];
      neg_q  <= sa ^ sb;
      neg_r  <= sa;
      wa     <= '0;
      wq     <= mag_a;
      wd     <= mag_b;
    end else if (wr_hi || wr_lo) begin
      busy <= 1'b0;
      if (wr_hi) hi <= wr_data;
      if (wr_lo) lo <= wr_data;
    end else if (busy) begin
      wa <= wa_n;
      wq <= wq_n;
      if (cnt == '0) begin
        busy <= 1'b0;
        hi   <= is_div ? rem_f : prod_f[2*W-1:W];
        lo   <= is_div ? quo_f : prod_f[W-1:0];
      end else begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  assert_start_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);
  assert_stall_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !stall);
  assert_write_hi_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hi && !start) |=> (hi == $past(wr_data)) && !busy);
  assert_write_lo_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lo && !start) |=> (lo == $past(wr_data)) && !busy);
  assert_hold_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start && !wr_hi && !wr_lo) |=> $stable(hi) && $stable(lo));
  assert_no_early_result_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (start && wr_hi && !$past(busy)) |=> $stable(hi));
endmodule

// File: tb/hilo_muldiv_tb.sv
module hilo_muldiv_tb;
  localparam int W = 4;
  localparam longint MASK = (64'd1 << W) - 1;
  localparam logic [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, wr_hi = 1'b0, wr_lo = 1'b0, rd_req = 1'b0;
  logic [1:0] op = 2'b00;
  logic [W-1:0] a = '0, b = '0, wr_data = '0;
  logic [W-1:0] hi, lo;
  logic busy, stall;
  int tests = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  hilo_muldiv #(.W(W)) u_dut (.clk(clk), .rst_n(rst_n), .start(start), .op(op),
    .a(a), .b(b), .wr_hi(wr_hi), .wr_lo(wr_lo), .wr_data(wr_data),
    .rd_req(rd_req), .hi(hi), .lo(lo), .busy(busy), .stall(stall));

  task automatic chk(input string req, input longint act, input longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic longint sv(input logic [1:0] o, input logic [W-1:0] x);
    return (!o[0] && x[W-1]) ? longint'(x) - (64'd1 << W) : longint'(x);
  endfunction

  function automatic logic [2*W-1:0] expect_res(input logic [1:0] o,
                                               input logic [W-1:0] x, input logic [W-1:0] y);
    longint xs = sv(o, x), ys = sv(o, y), p, q, r;
    if (!o[1]) begin
      p = xs * ys;
      return (2*W)'(p);
    end
    if (y == 0) begin
      if (o[0]) q = MASK;
      else q = (xs < 0) ? 1 : -1;
      r = x;
    end else if (!o[0] && x == MINV && ys == -1) begin
      q = MINV; r = 0;
    end else begin
      q = xs / ys; r = xs % ys;
    end
    return {W'(r & MASK), W'(q & MASK)};
  endfunction

  function automatic string tag(input logic [1:0] o, input logic [W-1:0] x,
                                input logic [W-1:0] y);
    if (o[1] && y == 0) return "R5";
    if (o == 2'b10 && x == MINV && y == '1) return "R6";
    case (o)
      2'b01: return "R1";
      2'b00: return "R2";
      2'b11: return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic run_op(input logic [1:0] o, input logic [W-1:0] x, input logic [W-1:0] y,
                        input bit chk_timing);
    int n = 0;
    logic [2*W-1:0] e = expect_res(o, x, y);
    @(negedge clk); start = 1'b1; op = o; a = x; b = y; rd_req = chk_timing;
    @(negedge clk); start = 1'b0;
    while (busy && n < 100) begin
      n++;
      if (chk_timing) chk("R8 stall while busy", stall, 1);
      @(negedge clk);
    end
    if (chk_timing) begin
      chk("R7 busy length", n, W);
      chk("R8 no stall when idle", stall, 0);
    end
    rd_req = 1'b0;
    chk({tag(o, x, y), " hi"}, hi, e[2*W-1:W]);
    chk({tag(o, x, y), " lo"}, lo, e[W-1:0]);
  endtask

  task automatic write_reg(input bit h, input bit l, input logic [W-1:0] d);
    @(negedge clk); wr_hi = h; wr_lo = l; wr_data = d;
    @(negedge clk); wr_hi = 1'b0; wr_lo = 1'b0;
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [2*W-1:0] e;
    repeat (3) @(negedge clk);
    chk("R12 reset hi", hi, 0);
    chk("R12 reset lo", lo, 0);
    chk("R7 reset busy", busy, 0);
    rst_n = 1'b1;

    for (int o = 0; o < 4; o++)
      for (int x = 0; x < (1 << W); x++)
        for (int y = 0; y < (1 << W); y++)
          run_op(2'(o), W'(x), W'(y), (x == y));

    write_reg(1'b1, 1'b0, 4'h5);
    chk("R9 direct hi", hi, 5);
    write_reg(1'b0, 1'b1, 4'hA);
    chk("R9 direct lo", lo, 4'hA);
    rd_req = 1'b1;
    repeat (5) @(negedge clk);
    chk("R12 hold hi", hi, 5);
    chk("R12 hold lo", lo, 4'hA);
    chk("R8 idle no stall", stall, 0);
    rd_req = 1'b0;

    @(negedge clk); start = 1'b1; op = 2'b11; a = 4'hF; b = 4'h2;
    @(negedge clk); start = 1'b0;
    @(negedge clk); wr_lo = 1'b1; wr_data = 4'h3;
    @(negedge clk); wr_lo = 1'b0;
    chk("R9 cancel busy", busy, 0);
    chk("R9 cancel lo", lo, 3);
    chk("R9 cancel keeps hi", hi, 5);
    repeat (W + 2) @(negedge clk);
    chk("R9 cancel no late hi", hi, 5);
    chk("R9 cancel no late lo", lo, 3);

    e = expect_res(2'b00, 4'h7, 4'hD);
    @(negedge clk); start = 1'b1; op = 2'b11; a = 4'hE; b = 4'h3;
    @(negedge clk); start = 1'b0;
    @(negedge clk); start = 1'b1; op = 2'b00; a = 4'h7; b = 4'hD;
    @(negedge clk); start = 1'b0;
    repeat (W - 1) @(negedge clk);
    chk("R10 still busy after restart", busy, 1);
    @(negedge clk);
    chk("R10 done after restart", busy, 0);
    chk("R10 restart hi", hi, e[2*W-1:W]);
    chk("R10 restart lo", lo, e[W-1:0]);

    e = expect_res(2'b01, 4'h6, 4'h7);
    @(negedge clk); start = 1'b1; op = 2'b01; a = 4'h6; b = 4'h7;
    wr_hi = 1'b1; wr_lo = 1'b1; wr_data = 4'h9;
    @(negedge clk); start = 1'b0; wr_hi = 1'b0; wr_lo = 1'b0;
    chk("R11 busy despite write", busy, 1);
    repeat (W) @(negedge clk);
    chk("R11 hi from op", hi, e[2*W-1:W]);
    chk("R11 lo from op", lo, e[W-1:0]);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule